// File: doc/BRIEF.md
# Predicated Vector Unsigned-Minimum Reduction

This unit collapses one wide vector operand into a single scalar: the smallest unsigned element among those that a byte-granular predicate marks as taking part. A 2-bit size code is supplied with each operand. It chooses at run time whether the same VL-bit operand is split into 8-, 16-, 32- or 64-bit elements. Elements that the predicate leaves out behave as the largest unsigned value at that width, so they can never be chosen. An operand with no participating elements therefore yields all ones at the element width. The unit produces no condition flags.

The datapath runs through two registered stages. In the first stage (capture), each 64-bit lane applies the predicate and reduces its own elements with a balanced comparison tree for every size. The lane then keeps the candidate that matches the size code. Each lane's candidate is zero-extended to 64 bits and registered. In the second stage (merge), a balanced tree across the lanes takes the unsigned minimum of those candidates and registers it as the output. A new operand can be accepted on every cycle. There is no stall path: each accepted operand moves through capture and merge in two consecutive edges. The result is placed in the low element-width bits of a VL-wide scalar, and every bit above it is zero.

Top module: `vec_umin_reduce`

## Requirements
- R1: The size code `in_size` selects the element width: 2'b00 gives 8 bits, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64. The operand holds VL/width elements, and element e occupies `in_vec` bits [e*width +: width].
- R2: Element e takes part when predicate bit `in_pred[e*width/8]` is set, which is the lowest bit of that element's byte group. The other predicate bits of the group have no effect on the result.
- R3: The result is the smallest unsigned value among the participating elements.
- R4: The values held in non-participating elements never change the result, even when they are smaller than every participating element.
- R5: With no participating element, the result is all ones at the selected width.
- R6: The result sits in `out_scalar[width-1:0]`, and every bit of `out_scalar` above the width is zero.
- R7: `out_valid` is high for exactly one cycle, two clock cycles after the cycle in which `in_valid` was high. Operands may arrive on consecutive cycles, and each one yields its own result in order.
- R8: A synchronous active-high `rst` clears `out_valid` and `out_scalar` to zero and discards any operand in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_vec | input | VL | Vector operand |
| in_pred | input | VL/8 | Predicate, one bit per operand byte |
| in_size | input | 2 | Element size code |
| out_valid | output | 1 | Result strobe |
| out_scalar | output | VL | Zero-extended minimum |

## Verification
The bench builds the unit with its default VL of 256, which gives four 64-bit lanes and a two-level merge tree. With that width, the minimum can sit in any lane and at any position inside a lane, including a 64-bit element that fills a whole lane. Predicates whose only set bits are the non-lowest bits of each group test the mapping from predicate bytes to elements at every size. Sequences of back-to-back operands, interleaved with gaps and a reset issued while an operand is in flight, test the fixed two-cycle spacing of results.

// File: rtl/vumin_pkg.sv
package vumin_pkg;

    localparam int unsigned LANE_W = 64;

    typedef enum logic [1:0] {
        ESZ_8  = 2'b00,
        ESZ_16 = 2'b01,
        ESZ_32 = 2'b10,
        ESZ_64 = 2'b11
    } esz_e;

    function automatic int unsigned esz_bits(esz_e s);
        return 32'd8 << s;
    endfunction

    function automatic logic [LANE_W-1:0] esz_ones(esz_e s);
        logic [LANE_W-1:0] r;
        unique case (s)
            ESZ_8:  r = 64'h0000_0000_0000_00FF;
            ESZ_16: r = 64'h0000_0000_0000_FFFF;
            ESZ_32: r = 64'h0000_0000_FFFF_FFFF;
            ESZ_64: r = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vumin_min_tree.sv
// Balanced unsigned-minimum tree; N must be a power of two.
module vumin_min_tree #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 64
) (
    input  logic [N*W-1:0] leaves,
    output logic [W-1:0]   min_out
);

    localparam int unsigned LVLS = $clog2(N);

    for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
        localparam int unsigned CNT = N >> l;
        logic [CNT*W-1:0] vals;
        if (l == 0) begin : g_base
            assign vals = leaves;
        end else begin : g_step
            for (genvar i = 0; i < CNT; i++) begin : g_cmp
                logic [W-1:0] lo_in;
                logic [W-1:0] hi_in;
                assign lo_in = g_lvl[l-1].vals[(2*i)*W +: W];
                assign hi_in = g_lvl[l-1].vals[(2*i+1)*W +: W];
                assign vals[i*W +: W] = (hi_in < lo_in) ? hi_in : lo_in;
            end
        end
    end

    assign min_out = g_lvl[LVLS].vals;

endmodule

// File: rtl/vumin_chunk_min.sv
// One 64-bit lane: predicate masking and in-lane reduction for all sizes.
module vumin_chunk_min
    import vumin_pkg::*;
#(
    parameter int unsigned CW = LANE_W
) (
    input  logic [CW-1:0]   data,
    input  logic [CW/8-1:0] pred,
    input  esz_e            size,
    output logic [CW-1:0]   min_out
);

    logic [CW-1:0] cand [4];

    for (genvar g = 0; g < 4; g++) begin : g_size
        localparam int unsigned EW = 8 << g;
        localparam int unsigned NE = CW / EW;
        logic [NE*EW-1:0] masked;
        logic [EW-1:0]    best;

        for (genvar e = 0; e < NE; e++) begin : g_elem
            assign masked[e*EW +: EW] = pred[(e*EW)/8] ? data[e*EW +: EW]
                                                      : {EW{1'b1}};
        end

        vumin_min_tree #(.N(NE), .W(EW)) u_tree (
            .leaves  (masked),
            .min_out (best)
        );

        assign cand[g] = CW'(best);
    end

    always_comb begin
        unique case (size)
            ESZ_8:  min_out = cand[0];
            ESZ_16: min_out = cand[1];
            ESZ_32: min_out = cand[2];
            ESZ_64: min_out = cand[3];
        endcase
    end

endmodule

// File: rtl/vec_umin_reduce.sv
module vec_umin_reduce
    import vumin_pkg::*;
#(
    parameter int unsigned VL = 256
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [VL-1:0]   in_vec,
    input  logic [VL/8-1:0] in_pred,
    input  logic [1:0]      in_size,
    output logic            out_valid,
    output logic [VL-1:0]   out_scalar
);

    localparam int unsigned NCHUNK  = VL / LANE_W;
    localparam int unsigned PRED_PL = LANE_W / 8;

    esz_e              size_sel;
    logic [VL-1:0]     lane_min;
    logic              cap_valid;
    logic [VL-1:0]     cap_min;
    logic [LANE_W-1:0] merge_min;
    logic [LANE_W-1:0] res_q;

    assign size_sel = esz_e'(in_size);

    // Capture stage: per-lane masking and reduction
    for (genvar c = 0; c < NCHUNK; c++) begin : g_lane
        vumin_chunk_min #(.CW(LANE_W)) u_lane (
            .data    (in_vec[c*LANE_W +: LANE_W]),
            .pred    (in_pred[c*PRED_PL +: PRED_PL]),
            .size    (size_sel),
            .min_out (lane_min[c*LANE_W +: LANE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_valid <= 1'b0;
            cap_min   <= '0;
        end else begin
            cap_valid <= in_valid;
            if (in_valid) begin
                cap_min <= lane_min;
            end
        end
    end

    // Merge stage: cross-lane tree
    vumin_min_tree #(.N(NCHUNK), .W(LANE_W)) u_merge (
        .leaves  (cap_min),
        .min_out (merge_min)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            out_valid <= cap_valid;
            if (cap_valid) begin
                res_q <= merge_min;
            end
        end
    end

    assign out_scalar = VL'(res_q);

endmodule

// File: rtl/vumin_checker.sv
module vumin_checker
    import vumin_pkg::*;
#(
    parameter int unsigned VL = 256
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [VL/8-1:0] in_pred,
    input logic [1:0]      in_size,
    input logic            out_valid,
    input logic [VL-1:0]   out_scalar
);

    logic        any_now;
    int unsigned grp;
    logic        v1, v2, any1, any2, rst_q;
    esz_e        sz1, sz2;

    always_comb begin
        any_now = 1'b0;
        grp = esz_bits(esz_e'(in_size)) / 8;
        for (int unsigned b = 0; b < VL/8; b++) begin
            if ((b % grp) == 0 && in_pred[b]) any_now = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            v1 <= 1'b0; v2 <= 1'b0;
            any1 <= 1'b0; any2 <= 1'b0;
            sz1 <= ESZ_8; sz2 <= ESZ_8;
        end else begin
            v1 <= in_valid; v2 <= v1;
            any1 <= any_now; any2 <= any1;
            sz1 <= esz_e'(in_size); sz2 <= sz1;
        end
    end

    assert_out_valid_latency_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid == v2);

    assert_upper_bits_zero_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_scalar >> esz_bits(sz2)) == '0));

    assert_empty_gives_ones_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !any2) |-> (out_scalar == VL'(esz_ones(sz2))));

    assert_reset_clears_valid_R8: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (!out_valid && out_scalar == '0));

endmodule

bind vec_umin_reduce vumin_checker #(.VL(VL)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_pred    (in_pred),
    .in_size    (in_size),
    .out_valid  (out_valid),
    .out_scalar (out_scalar)
);

// File: tb/vec_umin_reduce_test.sv
`timescale 1ns/1ps
module vec_umin_reduce_test;

    localparam int VL = 256;

    typedef struct {
        logic [VL-1:0] data;
        int            due;
        int            sz;
        string         tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic [VL-1:0]   in_vec;
    logic [VL/8-1:0] in_pred;
    logic [1:0]      in_size;
    logic            out_valid;
    logic [VL-1:0]   out_scalar;

    exp_t expq[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   chk_en = 1'b0;

    vec_umin_reduce #(.VL(VL)) uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_vec     (in_vec),
        .in_pred    (in_pred),
        .in_size    (in_size),
        .out_valid  (out_valid),
        .out_scalar (out_scalar)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc = cyc + 1;

    task automatic check(bit ok, string tag, string what, logic [VL-1:0] act, logic [VL-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [VL-1:0] model(logic [VL-1:0] v, logic [VL/8-1:0] p, int sz);
        int          ew   = 8 << sz;
        logic [63:0] m    = (ew == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << ew) - 64'd1);
        logic [63:0] best = m;
        logic [63:0] el;
        for (int e = 0; e < VL/ew; e++) begin
            if (p[e*ew/8]) begin
                el = 64'(v >> (e*ew)) & m;
                if (el < best) best = el;
            end
        end
        return VL'(best);
    endfunction

    function automatic logic [VL/8-1:0] low_mask(int sz);
        logic [VL/8-1:0] r = '0;
        int g = (8 << sz) / 8;
        for (int b = 0; b < VL/8; b++) if (b % g == 0) r[b] = 1'b1;
        return r;
    endfunction

    function automatic logic [VL-1:0] rand_vec();
        logic [VL-1:0] r;
        for (int i = 0; i < VL/32; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    function automatic logic [VL/8-1:0] rand_pred();
        logic [VL/8-1:0] r;
        for (int i = 0; i < VL/8; i++) r[i] = $urandom_range(0, 1) == 1;
        return r;
    endfunction

    // Result checking every cycle
    always @(negedge clk) begin
        exp_t x;
        if (chk_en) begin
            if (expq.size() > 0 && expq[0].due == cyc) begin
                x = expq.pop_front();
                check(out_valid == 1'b1, "R7", "result strobe", VL'(out_valid), VL'(1));
                check(out_scalar == x.data, x.tag, "result value", out_scalar, x.data);
                check((out_scalar >> (8 << x.sz)) == '0, "R6", "bits above width", out_scalar, x.data);
            end else begin
                check(out_valid == 1'b0, "R7", "idle strobe", VL'(out_valid), '0);
            end
        end
    end

    task automatic send(logic [VL-1:0] v, logic [VL/8-1:0] p, int sz, string tag);
        exp_t x;
        @(negedge clk);
        in_valid = 1'b1;
        in_vec   = v;
        in_pred  = p;
        in_size  = 2'(sz);
        x.data = model(v, p, sz);
        x.due  = cyc + 2;
        x.sz   = sz;
        x.tag  = tag;
        expq.push_back(x);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_vec   = rand_vec();
            in_pred  = rand_pred();
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [VL-1:0]   v;
        logic [VL/8-1:0] p;
        rst = 1'b1; in_valid = 1'b0; in_vec = '0; in_pred = '0; in_size = 2'b00;
        repeat (3) @(negedge clk);
        // R8: reset state
        check(out_valid == 1'b0, "R8", "reset strobe", VL'(out_valid), '0);
        check(out_scalar == '0, "R8", "reset scalar", out_scalar, '0);
        @(negedge clk);
        rst = 1'b0;
        chk_en = 1'b1;

        // R1: same bytes read at each width
        for (int i = 0; i < VL/8; i++) v[i*8 +: 8] = 8'(8'hC7 - 3*i);
        for (int sz = 0; sz < 4; sz++) send(v, '1, sz, "R1");
        idle(3);

        // R2: only non-lowest predicate bits set -> nothing active
        for (int sz = 1; sz < 4; sz++) send('0, ~low_mask(sz), sz, "R2");
        // R2: only lowest bits set -> every element active
        for (int sz = 0; sz < 4; sz++) send(rand_vec(), low_mask(sz), sz, "R2");
        idle(3);

        // R4: inactive elements hold zero, active ones larger
        for (int sz = 0; sz < 4; sz++) begin
            int ew = 8 << sz;
            v = rand_vec();
            p = rand_pred();
            p[0] = 1'b1;
            for (int e = 0; e < VL/ew; e++) begin
                if (!p[e*ew/8]) begin
                    for (int b = 0; b < ew; b++) v[e*ew + b] = 1'b0;
                end else begin
                    v[e*ew + ew - 1] = 1'b1;
                end
            end
            send(v, p, sz, "R4");
        end
        idle(2);

        // R5: empty predicate at every width
        for (int sz = 0; sz < 4; sz++) send(rand_vec(), '0, sz, "R5");
        idle(2);

        // R3: all-ones operand, all active
        for (int sz = 0; sz < 4; sz++) send('1, '1, sz, "R3");
        // R3: single active element at the top position
        for (int sz = 0; sz < 4; sz++) begin
            p = '0;
            p[VL/8 - (8 << sz)/8] = 1'b1;
            send(rand_vec(), p, sz, "R3");
        end
        idle(3);

        // R3/R7: random traffic, back-to-back with gaps
        for (int n = 0; n < 400; n++) begin
            send(rand_vec(), rand_pred(), $urandom_range(0, 3), "R3");
            if ($urandom_range(0, 4) == 0) idle($urandom_range(1, 3));
        end
        idle(4);

        // R8: reset while an operand is in flight
        chk_en = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_vec = rand_vec(); in_pred = '1; in_size = 2'b01;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R8", "flush strobe", VL'(out_valid), '0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R8", "flush stage", VL'(out_valid), '0);
        check(out_scalar == '0, "R8", "flush scalar", out_scalar, '0);
        chk_en = 1'b1;
        send(rand_vec(), rand_pred(), 3, "R3");
        idle(4);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule